// File: doc/BRIEF.md
# Mode-Selected Arithmetic Logic Unit

This block is a purely combinational N-bit arithmetic logic unit. It takes two operands, a carry input and a three-bit operation select. One select bit picks between an arithmetic section and a bitwise logic section. The other two bits, together with the carry input, pick the specific operation. The result and four status flags (sign, zero, carry and overflow) come out in the same cycle.

The arithmetic section is built around a single ripple adder. Its first input is always operand A. Its second input is steered to zero, B, the bitwise complement of B, or all ones, and the carry input feeds the adder's carry-in. With this one structure the block covers transfer, increment, add, add with carry, subtract with borrow, subtract and decrement. The logic section gives AND, OR, XOR and the complement of A. A datapath controller drives the select lines from its decoded operation. The flags are meant to be captured by a status register outside the block.

Top module: `mode_alu`

## Requirements
- R1: `mode_logic` = 0 selects the arithmetic section and `mode_logic` = 1 selects the logic section, so the same operands and `func_sel` give different results in the two modes.
- R2: Arithmetic with `func_sel` = 2'b00 adds zero. The result is A when `carry_in` = 0 and A+1 (mod 2^WIDTH) when `carry_in` = 1.
- R3: Arithmetic with `func_sel` = 2'b01 adds B. The result is A+B when `carry_in` = 0 and A+B+1 when `carry_in` = 1, both mod 2^WIDTH.
- R4: Arithmetic with `func_sel` = 2'b10 adds the complement of B. The result is A+~B (A-B-1, subtract with borrow) when `carry_in` = 0 and A-B when `carry_in` = 1.
- R5: Arithmetic with `func_sel` = 2'b11 adds all ones. The result is A-1 when `carry_in` = 0 and A when `carry_in` = 1.
- R6: In logic mode, `func_sel` 2'b00 gives A AND B, 2'b01 gives A OR B, 2'b10 gives A XOR B and 2'b11 gives NOT A.
- R7: In logic mode, `carry_in` has no effect on any output.
- R8: In arithmetic mode, `carry_out` is the carry out of the adder's most significant bit. For subtraction, 1 means no borrow. In logic mode `carry_out` is 0.
- R9: In arithmetic mode, `flag_ovf` is 1 exactly when the two adder inputs have the same sign bit and the result's sign bit differs from it, which is two's-complement overflow. In logic mode `flag_ovf` is 0.
- R10: `flag_zero` is 1 exactly when the result is all zeros, and `flag_sign` equals the result's most significant bit, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand, always the adder's first input |
| op_b | input | WIDTH | Second operand, steered or combined per select |
| carry_in | input | 1 | Adder carry-in; ignored in logic mode |
| mode_logic | input | 1 | 0 = arithmetic section, 1 = logic section |
| func_sel | input | 2 | Operation within the chosen section |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry out of the top bit (arithmetic only) |
| flag_sign | output | 1 | Most significant bit of the result |
| flag_zero | output | 1 | Result is all zeros |
| flag_ovf | output | 1 | Two's-complement overflow (arithmetic only) |

## Verification
Carry and overflow both come from the adder's top stage, so they can change in the same evaluation. Cases where they must disagree are the ones that matter: a signed overflow with no unsigned carry, and an unsigned carry with no signed overflow. An exhaustive sweep of a 4-bit instance over every operand pair, carry input and select value produces both kinds, along with the zero result that comes together with a carry out of subtracting equal operands. Each output is compared against a reference built from integer arithmetic in the bench.

// File: rtl/mode_alu_pkg.sv
// Package: shared select encodings for the mode-selected ALU.
// Assumes: two function-select bits; the encodings below are fixed by behaviour.
package mode_alu_pkg;

    // Second adder input chosen by func_sel in arithmetic mode.
    typedef enum logic [1:0] {
        STEER_ZERO = 2'b00,
        STEER_B    = 2'b01,
        STEER_NOTB = 2'b10,
        STEER_ONES = 2'b11
    } steer_e;

    // Bitwise function chosen by func_sel in logic mode.
    typedef enum logic [1:0] {
        LGC_AND  = 2'b00,
        LGC_OR   = 2'b01,
        LGC_XOR  = 2'b10,
        LGC_NOTA = 2'b11
    } lgc_e;

endpackage

// File: rtl/mode_alu_steer.sv
// Module: selects the adder's second input from zero, B, ~B or all ones.
// Assumes: purely combinational; select encoding from mode_alu_pkg.
module mode_alu_steer
    import mode_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] b_in,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] b_eff
);

    // Steer the B-side operand per the arithmetic select table.
    always_comb begin
        unique case (steer_e'(sel))
            STEER_ZERO: b_eff = '0;
            STEER_B:    b_eff = b_in;
            STEER_NOTB: b_eff = ~b_in;
            default:    b_eff = '1;
        endcase
    end

endmodule

// File: rtl/mode_alu_adder.sv
// Module: WIDTH-bit ripple-carry adder exposing the carry into and out of the MSB.
// Assumes: WIDTH >= 2; combinational; no pipelining.
module mode_alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] add_a,
    input  logic [WIDTH-1:0] add_b,
    input  logic             add_cin,
    output logic [WIDTH-1:0] add_sum,
    output logic             carry_msb_in,
    output logic             carry_msb_out
);

    localparam int CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] chain;

    assign chain[0] = add_cin;

    // One full-adder cell per bit, carries rippling upward.
    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        assign add_sum[g]   = add_a[g] ^ add_b[g] ^ chain[g];
        assign chain[g+1]   = (add_a[g] & add_b[g]) | (chain[g] & (add_a[g] ^ add_b[g]));
    end

    assign carry_msb_in  = chain[WIDTH-1];
    assign carry_msb_out = chain[WIDTH];

    // Check the ripple chain against a plain arithmetic sum (R8).
    always_comb begin
        if (!$isunknown({add_a, add_b, add_cin})) begin
            a_r8_chain_sum: assert ({carry_msb_out, add_sum} ==
                ({1'b0, add_a} + {1'b0, add_b} + {{WIDTH{1'b0}}, add_cin}))
                else $error("adder chain disagrees with arithmetic sum");
        end
    end

endmodule

// File: rtl/mode_alu_logic.sv
// Module: bitwise logic section (AND, OR, XOR, NOT A).
// Assumes: combinational; carry input deliberately absent.
module mode_alu_logic
    import mode_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] la,
    input  logic [WIDTH-1:0] lb,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] lout
);

    // Pick one bitwise function per the logic select table.
    always_comb begin
        unique case (lgc_e'(sel))
            LGC_AND: lout = la & lb;
            LGC_OR:  lout = la | lb;
            LGC_XOR: lout = la ^ lb;
            default: lout = ~la;
        endcase
    end

endmodule

// File: rtl/mode_alu.sv
// Module: top of the mode-selected ALU; muxes the sections and forms flags.
// Assumes: fully combinational; no reset or clock; WIDTH >= 2.
module mode_alu #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic             mode_logic,
    input  logic [1:0]       func_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             flag_sign,
    output logic             flag_zero,
    output logic             flag_ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] arith_sum;
    logic [WIDTH-1:0] logic_out;
    logic             c_into_msb;
    logic             c_out_msb;

    mode_alu_steer #(.WIDTH(WIDTH)) u_steer (
        .b_in  (op_b),
        .sel   (func_sel),
        .b_eff (b_eff)
    );

    mode_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .add_a         (op_a),
        .add_b         (b_eff),
        .add_cin       (carry_in),
        .add_sum       (arith_sum),
        .carry_msb_in  (c_into_msb),
        .carry_msb_out (c_out_msb)
    );

    mode_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .la   (op_a),
        .lb   (op_b),
        .sel  (func_sel),
        .lout (logic_out)
    );

    // Choose the section output and gate arithmetic-only flags.
    always_comb begin
        if (mode_logic) begin
            result    = logic_out;
            carry_out = 1'b0;
            flag_ovf  = 1'b0;
        end else begin
            result    = arith_sum;
            carry_out = c_out_msb;
            flag_ovf  = c_into_msb ^ c_out_msb;
        end
    end

    // Derive sign and zero from the final result in either mode.
    assign flag_sign = result[MSB];
    assign flag_zero = ~|result;

    // Cross-module checks on ports and section outputs.
    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in, mode_logic, func_sel})) begin
            a_r8_logic_carry_clear: assert (!mode_logic || !carry_out)
                else $error("carry set in logic mode");
            a_r9_logic_ovf_clear: assert (!mode_logic || !flag_ovf)
                else $error("overflow set in logic mode");
            a_r9_ovf_signs: assert (!flag_ovf ||
                ((op_a[MSB] == b_eff[MSB]) && (result[MSB] != op_a[MSB])))
                else $error("overflow without sign mismatch");
            a_r2_transfer: assert (mode_logic || func_sel != 2'b00 || carry_in ||
                result == op_a)
                else $error("transfer with zero operand altered A");
            a_r5_transfer: assert (mode_logic || func_sel != 2'b11 || !carry_in ||
                (result == op_a && carry_out))
                else $error("all-ones plus carry did not return A");
            a_r10_zero_not_neg: assert (!flag_zero || !flag_sign)
                else $error("zero and sign both set");
        end
    end

endmodule

// File: tb/mode_alu_tb.sv
// Bench: exhaustive sweep of a 4-bit instance against an integer reference.
module mode_alu_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int MASK       = (1 << W) - 1;
    localparam int WATCHDOG   = 50000;

    logic         clk = 1'b0;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         carry_in;
    logic         mode_logic;
    logic [1:0]   func_sel;
    logic [W-1:0] result;
    logic         carry_out;
    logic         flag_sign;
    logic         flag_zero;
    logic         flag_ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    mode_alu #(.WIDTH(W)) u_dut (
        .op_a       (op_a),
        .op_b       (op_b),
        .carry_in   (carry_in),
        .mode_logic (mode_logic),
        .func_sel   (func_sel),
        .result     (result),
        .carry_out  (carry_out),
        .flag_sign  (flag_sign),
        .flag_zero  (flag_zero),
        .flag_ovf   (flag_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s a=%0d b=%0d cin=%0d mode=%0d sel=%0d actual=%0d expected=%0d",
                     tag, what, op_a, op_b, carry_in, mode_logic, func_sel, act, exp);
        end
    endtask

    function automatic string result_tag(input bit m, input int s, input bit c);
        if (m) return c ? "R7" : "R6";
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic apply(input int a, input int b, input bit c, input bit m, input int s);
        @(negedge clk);
        op_a       = W'(a);
        op_b       = W'(b);
        carry_in   = c;
        mode_logic = m;
        func_sel   = 2'(s);
        #(CLK_PERIOD/4);
    endtask

    // Exhaustive sweep with arithmetic reference model.
    initial begin
        int bs, sum, exp_r, exp_c, exp_v;
        op_a = '0; op_b = '0; carry_in = 1'b0; mode_logic = 1'b0; func_sel = 2'b00;

        // R1: same operands and select, different mode gives different result.
        apply(5, 3, 1'b0, 1'b0, 1);
        check("R1", "arith add", int'(result), 8);
        apply(5, 3, 1'b0, 1'b1, 1);
        check("R1", "logic or", int'(result), 7);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int c = 0; c < 2; c++) begin
                    for (int a = 0; a <= MASK; a++) begin
                        for (int b = 0; b <= MASK; b++) begin
                            apply(a, b, c[0], m[0], s);
                            if (m == 0) begin
                                case (s)
                                    0: bs = 0;
                                    1: bs = b;
                                    2: bs = (~b) & MASK;
                                    default: bs = MASK;
                                endcase
                                sum   = a + bs + c;
                                exp_r = sum & MASK;
                                exp_c = (sum >> W) & 1;
                                exp_v = (((a >> (W-1)) & 1) == ((bs >> (W-1)) & 1)) &&
                                        (((exp_r >> (W-1)) & 1) != ((a >> (W-1)) & 1)) ? 1 : 0;
                            end else begin
                                case (s)
                                    0: exp_r = a & b;
                                    1: exp_r = a | b;
                                    2: exp_r = a ^ b;
                                    default: exp_r = (~a) & MASK;
                                endcase
                                exp_c = 0;
                                exp_v = 0;
                            end
                            check(result_tag(m[0], s, c[0]), "result", int'(result), exp_r);
                            check("R8", "carry", int'(carry_out), exp_c);
                            check("R9", "overflow", int'(flag_ovf), exp_v);
                            check("R10", "zero", int'(flag_zero), (exp_r == 0) ? 1 : 0);
                            check("R10", "sign", int'(flag_sign), (exp_r >> (W-1)) & 1);
                        end
                    end
                end
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule